// File: doc/BRIEF.md
# Two-Way Set-Associative Page Translation Buffer

This block keeps recently used virtual-to-physical page mappings close to the pipeline. It covers a 40-bit virtual address space and a 36-bit physical address space with 16 KB pages. A request carries a virtual address and an access kind (read, write or instruction fetch). One cycle later the block answers with exactly one of three outcomes: a hit with the translated physical address, a miss, or a permission fault.

A page-table walker sits outside the block. It answers a miss by presenting the new mapping on the fill port, and the block writes that mapping into the set the address indexes. The set holds two ways. An empty way is used first. Otherwise the victim is chosen from a per-entry reference bit, which is a cheap stand-in for least-recently-used order. Each entry also carries a dirty bit and a three-bit rights field. A single-cycle invalidate input discards every mapping at once, for example on an address-space switch.

Top module: `pg_xlate_tlb`

## Requirements
- R1: The set index is VA[21:14] and the tag is VA[39:22]; on a hit the physical address is the stored 22-bit frame number followed by VA[13:0] unchanged.
- R2: A request sampled on a clock edge produces rsp_valid high in the following cycle only, with exactly one of rsp_hit, rsp_miss and rsp_fault high; when rsp_valid is low all three are low, and after reset no response is flagged.
- R3: A lookup misses when neither way of the indexed set holds a valid entry with a matching tag; on a miss or fault, rsp_pa and rsp_dirty are zero.
- R4: The rights field uses bit 0 for read, bit 1 for write and bit 2 for fetch; req_kind 2'b00 is read, 2'b01 write, 2'b10 fetch, and 2'b11 is reserved and always faults on a matching entry. A matching entry that lacks the right gives a fault and changes no stored state.
- R5: A write hit sets the entry's dirty bit; rsp_dirty reports the stored dirty bit as it was before the access; a fill loads the dirty bit from fill_dirty.
- R6: A fill with no matching tag in the set goes into an invalid way, way 0 first, if one exists.
- R7: With both ways valid and no match, the victim is the way whose reference bit is clear (way 0 if both are clear); if both are set, both are cleared and way 0 is replaced. Hits and fills set the entry's reference bit.
- R8: A fill whose tag matches a valid entry of the set overwrites that entry in place and leaves the other way untouched.
- R9: inv_all clears every valid bit at the next edge; a fill in the same cycle lands after the clear and is valid afterwards.
- R10: When a fill and a looked-up request meet in the same cycle, the response reflects the contents before the fill, and the fill's writes take precedence over the lookup's reference and dirty updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 40 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| fill_valid | input | 1 | Fill strobe from the walker |
| fill_vpn | input | 26 | Virtual page number of the new mapping |
| fill_ppn | input | 22 | Physical frame number of the new mapping |
| fill_rights | input | 3 | Rights of the new mapping (bit0 read, bit1 write, bit2 fetch) |
| fill_dirty | input | 1 | Initial dirty bit of the new mapping |
| inv_all | input | 1 | Discard every mapping at the next edge |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Translation found and allowed |
| rsp_miss | output | 1 | No matching mapping |
| rsp_fault | output | 1 | Mapping found but access not allowed |
| rsp_pa | output | 36 | Physical address on a hit, zero otherwise |
| rsp_dirty | output | 1 | Stored dirty bit of the hit entry before this access |

## Verification
The hardest state to reach from the ports is a set whose two ways are both valid with both reference bits set. Only a chain of fills and hits leads there, and the eviction that follows clears the bits, which can be seen only through the next victim choice. The stimulus table builds this state in one set. It fills two ways, touches both, then adds a third page and checks which old page survives. A further fill then shows that the cleared reference bit steers the next eviction. Same-cycle collisions are produced by placing a fill in the exact cycle in which a registered request is answered. One collision is a refill in place against a write hit, where the dirty bit that is read back shows which write won.

// File: rtl/pg_tlb_pkg.sv
`timescale 1ns/1ps
package pg_tlb_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } acc_kind_e;

  localparam int RIGHTS_W = 3;
  localparam int RGT_RD   = 0;
  localparam int RGT_WR   = 1;
  localparam int RGT_EX   = 2;

  // Permission rule: one rights bit per access kind; the reserved kind never passes.
  function automatic logic kind_permitted(input logic [RIGHTS_W-1:0] rights,
                                          input acc_kind_e kind);
    case (kind)
      KIND_READ:  return rights[RGT_RD];
      KIND_WRITE: return rights[RGT_WR];
      KIND_FETCH: return rights[RGT_EX];
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pg_tlb_way.sv
`timescale 1ns/1ps
module pg_tlb_way #(
  parameter int SETS  = 256,
  parameter int IDX_W = 8,
  parameter int TAG_W = 18,
  parameter int PPN_W = 22,
  parameter int RGT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup read side
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [TAG_W-1:0] lk_tag,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [RGT_W-1:0] lk_rights,
  output logic             lk_dirty,
  // lookup state update
  input  logic             upd_we,
  input  logic             upd_dirty,
  // fill side
  input  logic [IDX_W-1:0] fl_idx,
  output logic             fl_valid,
  output logic             fl_ref,
  output logic [TAG_W-1:0] fl_tag,
  input  logic             fill_we,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [RGT_W-1:0] fill_rights,
  input  logic             fill_dirty,
  input  logic             ref_clr,
  input  logic             inv_all
);

  logic [TAG_W-1:0] tag_q    [SETS];
  logic [PPN_W-1:0] ppn_q    [SETS];
  logic [RGT_W-1:0] rights_q [SETS];
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  ref_q;
  logic [SETS-1:0]  dirty_q;

  // Payload storage: written only by a fill.
  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[fl_idx]    <= fill_tag;
      ppn_q[fl_idx]    <= fill_ppn;
      rights_q[fl_idx] <= fill_rights;
    end
  end

  // Status bits: later statements win, so the fill has the last word (R9, R10).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      if (inv_all)   valid_q <= '0;
      if (upd_we)    ref_q[lk_idx] <= 1'b1;
      if (upd_dirty) dirty_q[lk_idx] <= 1'b1;
      if (ref_clr)   ref_q[fl_idx] <= 1'b0;
      if (fill_we) begin
        valid_q[fl_idx] <= 1'b1;
        ref_q[fl_idx]   <= 1'b1;
        dirty_q[fl_idx] <= fill_dirty;
      end
    end
  end

  assign lk_valid  = valid_q[lk_idx];
  assign lk_tag    = tag_q[lk_idx];
  assign lk_ppn    = ppn_q[lk_idx];
  assign lk_rights = rights_q[lk_idx];
  assign lk_dirty  = dirty_q[lk_idx];
  assign fl_valid  = valid_q[fl_idx];
  assign fl_ref    = ref_q[fl_idx];
  assign fl_tag    = tag_q[fl_idx];

  // R9: a fill leaves its entry valid even under a simultaneous invalidate.
  p_fill_marks_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> valid_q[$past(fl_idx)]);

  // R9: an invalidate with no fill empties the whole way.
  p_inv_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fill_we) |=> (valid_q == '0));

  // R7: a fill always marks its entry as recently used.
  p_fill_sets_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> ref_q[$past(fl_idx)]);

endmodule

// File: rtl/pg_tlb_victim.sv
`timescale 1ns/1ps
module pg_tlb_victim (
  input  logic       inv_all,
  input  logic [1:0] set_valid,
  input  logic [1:0] set_ref,
  input  logic [1:0] set_match,
  output logic       victim,
  output logic       clr_refs
);

  logic [1:0] eff_valid;
  logic [1:0] eff_match;

  // An invalidate in the same cycle is seen first: the set looks empty.
  assign eff_valid = inv_all ? 2'b00 : set_valid;
  assign eff_match = eff_valid & set_match;

  // Priority: matching way (R8), empty way (R6), clear reference bit (R7).
  always_comb begin
    victim   = 1'b0;
    clr_refs = 1'b0;
    if (eff_match[0])       victim = 1'b0;
    else if (eff_match[1])  victim = 1'b1;
    else if (!eff_valid[0]) victim = 1'b0;
    else if (!eff_valid[1]) victim = 1'b1;
    else if (!set_ref[0])   victim = 1'b0;
    else if (!set_ref[1])   victim = 1'b1;
    else begin
      victim   = 1'b0;
      clr_refs = 1'b1;
    end
  end

endmodule

// File: rtl/pg_xlate_tlb.sv
`timescale 1ns/1ps
module pg_xlate_tlb
  import pg_tlb_pkg::*;
#(
  parameter int VA_W  = 40,
  parameter int PA_W  = 36,
  parameter int OFF_W = 14,
  parameter int SETS  = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_va,
  input  logic [1:0]      req_kind,
  input  logic            fill_valid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic [2:0]      fill_rights,
  input  logic            fill_dirty,
  input  logic            inv_all,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_pa,
  output logic            rsp_dirty
);

  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int PPN_W = PA_W - OFF_W;

  // Address arithmetic kept in functions (R1).
  function automatic logic [IDX_W-1:0] vpn_index(input logic [VPN_W-1:0] vpn);
    return vpn[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] vpn_tag(input logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1:IDX_W];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  // Registered request.
  logic            q_valid;
  logic [VA_W-1:0] q_va;
  acc_kind_e       q_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    q_va   <= req_va;
    q_kind <= acc_kind_e'(req_kind);
  end

  logic [VPN_W-1:0] q_vpn;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_want;
  assign q_vpn   = q_va[VA_W-1:OFF_W];
  assign lk_idx  = vpn_index(q_vpn);
  assign lk_want = vpn_tag(q_vpn);

  logic [IDX_W-1:0] fl_idx;
  logic [TAG_W-1:0] fl_want;
  assign fl_idx  = vpn_index(fill_vpn);
  assign fl_want = vpn_tag(fill_vpn);

  // Per-way wires.
  logic [WAYS-1:0]  lk_valid, lk_dirty, way_hit, upd_we, upd_dirty;
  logic [TAG_W-1:0] lk_tag    [WAYS];
  logic [PPN_W-1:0] lk_ppn    [WAYS];
  logic [2:0]       lk_rights [WAYS];
  logic [WAYS-1:0]  fl_valid, fl_ref, fl_match, fill_we, ref_clr;
  logic [TAG_W-1:0] fl_tag    [WAYS];

  logic victim, clr_refs;
  logic any_hit, allowed, hit_ok;
  logic [PPN_W-1:0] sel_ppn;
  logic [2:0]       sel_rights;
  logic             sel_dirty;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    pg_tlb_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W), .RGT_W(RIGHTS_W)
    ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_idx     (lk_idx),
      .lk_valid   (lk_valid[w]),
      .lk_tag     (lk_tag[w]),
      .lk_ppn     (lk_ppn[w]),
      .lk_rights  (lk_rights[w]),
      .lk_dirty   (lk_dirty[w]),
      .upd_we     (upd_we[w]),
      .upd_dirty  (upd_dirty[w]),
      .fl_idx     (fl_idx),
      .fl_valid   (fl_valid[w]),
      .fl_ref     (fl_ref[w]),
      .fl_tag     (fl_tag[w]),
      .fill_we    (fill_we[w]),
      .fill_tag   (fl_want),
      .fill_ppn   (fill_ppn),
      .fill_rights(fill_rights),
      .fill_dirty (fill_dirty),
      .ref_clr    (ref_clr[w]),
      .inv_all    (inv_all)
    );

    assign way_hit[w]   = lk_valid[w] && (lk_tag[w] == lk_want);
    assign fl_match[w]  = fl_valid[w] && (fl_tag[w] == fl_want);
    assign upd_we[w]    = q_valid && way_hit[w] && allowed;
    assign upd_dirty[w] = upd_we[w] && (q_kind == KIND_WRITE);
    assign fill_we[w]   = fill_valid && (victim == w[0]);
    // Only the way not being written loses its reference bit.
    assign ref_clr[w]   = fill_valid && clr_refs && (victim != w[0]);
  end

  pg_tlb_victim u_victim (
    .inv_all  (inv_all),
    .set_valid(fl_valid),
    .set_ref  (fl_ref),
    .set_match(fl_match),
    .victim   (victim),
    .clr_refs (clr_refs)
  );

  // Hit selection: a set never holds the same tag twice (R8), so the way hits are exclusive.
  assign any_hit    = |way_hit;
  assign sel_ppn    = way_hit[1] ? lk_ppn[1]    : lk_ppn[0];
  assign sel_rights = way_hit[1] ? lk_rights[1] : lk_rights[0];
  assign sel_dirty  = way_hit[1] ? lk_dirty[1]  : lk_dirty[0];
  assign allowed    = kind_permitted(sel_rights, q_kind);
  assign hit_ok     = q_valid && any_hit && allowed;

  assign rsp_valid = q_valid;
  assign rsp_hit   = hit_ok;
  assign rsp_miss  = q_valid && !any_hit;
  assign rsp_fault = q_valid && any_hit && !allowed;
  assign rsp_pa    = hit_ok ? join_pa(sel_ppn, q_va[OFF_W-1:0]) : '0;
  assign rsp_dirty = hit_ok && sel_dirty;

  // R2: a response carries exactly one outcome.
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  // R2: no outcome without the strobe.
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_hit, rsp_miss, rsp_fault} == 3'b000));

  // R2: the strobe follows a request by one cycle.
  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R1: the page offset passes through untouched.
  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));

  // R6: with a free way and no match, the selector never picks an occupied way.
  p_prefer_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inv_all && (fl_match == '0) && !(&fl_valid)) |-> !fl_valid[victim]);

  // R4: a fault leaves the reference and dirty bits alone.
  p_fault_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> ((upd_we == '0) && (upd_dirty == '0)));

endmodule

// File: tb/pg_xlate_tlb_test.sv
`timescale 1ns/1ps
module pg_xlate_tlb_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [39:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        fill_valid = 1'b0;
  logic [25:0] fill_vpn = '0;
  logic [21:0] fill_ppn = '0;
  logic [2:0]  fill_rights = '0;
  logic        fill_dirty = 1'b0;
  logic        inv_all = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
  logic [35:0] rsp_pa;

  always #2 clk = ~clk;  // 250 MHz

  pg_xlate_tlb uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_va(req_va), .req_kind(req_kind),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rights(fill_rights), .fill_dirty(fill_dirty), .inv_all(inv_all),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_dirty(rsp_dirty)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  // Outcome codes used by the bench only.
  localparam logic [1:0] E_NONE = 2'd0, E_HIT = 2'd1, E_MISS = 2'd2, E_FAULT = 2'd3;
  localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_EX = 2'b10, K_RS = 2'b11;

  // Page numbers: {tag, index}; index lands in VA[21:14] (R1).
  localparam logic [25:0] VPN_A0 = {18'h00001, 8'h05};
  localparam logic [25:0] VPN_A1 = {18'h00002, 8'h05};
  localparam logic [25:0] VPN_A2 = {18'h00003, 8'h05};
  localparam logic [25:0] VPN_B  = {18'h3FFFF, 8'hFF};
  localparam logic [25:0] VPN_E  = {18'h00ABC, 8'h40};

  typedef struct packed {
    logic        fill;
    logic [25:0] vpn;
    logic [13:0] off;
    logic [1:0]  kind;
    logic [21:0] ppn;     // fill data, or expected frame on a hit
    logic [2:0]  rights;
    logic        fdirty;  // fill dirty, or expected rsp_dirty on a hit
    logic [1:0]  exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, VPN_A0, 14'h1ABC, K_RD, 22'h0,      3'b000, 1'b0, E_MISS,  4'd3},  // R3 empty set
    '{1'b1, VPN_A0, 14'h0,    K_RD, 22'h0ABCD,  3'b011, 1'b0, E_NONE,  4'd6},  // R6 way 0
    '{1'b0, VPN_A0, 14'h1ABC, K_RD, 22'h0ABCD,  3'b000, 1'b0, E_HIT,   4'd1},  // R1
    '{1'b0, VPN_A0, 14'h0000, K_WR, 22'h0ABCD,  3'b000, 1'b0, E_HIT,   4'd5},  // R5 old dirty
    '{1'b0, VPN_A0, 14'h3FFF, K_RD, 22'h0ABCD,  3'b000, 1'b1, E_HIT,   4'd5},  // R5 now dirty
    '{1'b0, VPN_A0, 14'h0123, K_EX, 22'h0,      3'b000, 1'b0, E_FAULT, 4'd4},  // R4 no fetch
    '{1'b1, VPN_A1, 14'h0,    K_RD, 22'h12345,  3'b001, 1'b0, E_NONE,  4'd6},  // R6 way 1
    '{1'b0, VPN_A1, 14'h0042, K_WR, 22'h0,      3'b000, 1'b0, E_FAULT, 4'd4},  // R4 read-only
    '{1'b0, VPN_A1, 14'h0042, K_RD, 22'h12345,  3'b000, 1'b0, E_HIT,   4'd4},  // R4 fault left dirty clear
    '{1'b0, VPN_A0, 14'h0042, K_RD, 22'h0ABCD,  3'b000, 1'b1, E_HIT,   4'd6},  // R6 both kept
    '{1'b1, VPN_A2, 14'h0,    K_RD, 22'h00777,  3'b111, 1'b0, E_NONE,  4'd7},  // R7 both ref set
    '{1'b0, VPN_A0, 14'h0042, K_RD, 22'h0,      3'b000, 1'b0, E_MISS,  4'd7},  // R7 way 0 evicted
    '{1'b1, VPN_A0, 14'h0,    K_RD, 22'h00888,  3'b111, 1'b0, E_NONE,  4'd7},  // R7 ref-clear way
    '{1'b0, VPN_A1, 14'h0042, K_RD, 22'h0,      3'b000, 1'b0, E_MISS,  4'd7},  // R7 way 1 evicted
    '{1'b0, VPN_A2, 14'h0042, K_RD, 22'h00777,  3'b000, 1'b0, E_HIT,   4'd7},
    '{1'b0, VPN_A0, 14'h2222, K_EX, 22'h00888,  3'b000, 1'b0, E_HIT,   4'd7},
    '{1'b1, VPN_A0, 14'h0,    K_RD, 22'h00999,  3'b001, 1'b1, E_NONE,  4'd8},  // R8 refill in place
    '{1'b0, VPN_A2, 14'h0042, K_RD, 22'h00777,  3'b000, 1'b0, E_HIT,   4'd8},  // R8 other way kept
    '{1'b0, VPN_A0, 14'h0042, K_RD, 22'h00999,  3'b000, 1'b1, E_HIT,   4'd8},
    '{1'b0, VPN_A0, 14'h0042, K_RS, 22'h0,      3'b000, 1'b0, E_FAULT, 4'd4},  // R4 reserved kind
    '{1'b1, VPN_B,  14'h0,    K_RD, 22'h3FFFFF, 3'b111, 1'b0, E_NONE,  4'd1},
    '{1'b0, VPN_B,  14'h3FFF, K_WR, 22'h3FFFFF, 3'b000, 1'b0, E_HIT,   4'd1}   // R1 all-ones
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [1:0] got_code();
    if (!rsp_valid) return E_NONE;
    if (rsp_hit && !rsp_miss && !rsp_fault) return E_HIT;
    if (rsp_miss && !rsp_hit && !rsp_fault) return E_MISS;
    if (rsp_fault && !rsp_hit && !rsp_miss) return E_FAULT;
    return E_NONE;
  endfunction

  // Compare the current response with an expectation; PA and dirty are zero unless a hit (R3).
  task automatic check_rsp(input string req, input logic [1:0] e, input logic [21:0] ppn,
                           input logic [13:0] off, input logic ed);
    logic [63:0] a, x;
    a = {25'd0, got_code(), rsp_pa, rsp_dirty};
    x = {25'd0, e, (e == E_HIT) ? {ppn, off} : 36'd0, (e == E_HIT) ? ed : 1'b0};
    check(a == x, req, "response {code,pa,dirty}", a, x);
  endtask

  task automatic start_lookup(input logic [25:0] vpn, input logic [13:0] off, input logic [1:0] k);
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = {vpn, off};
    req_kind  = k;
  endtask

  // After return, the response to the request is on the outputs.
  task automatic lookup(input logic [25:0] vpn, input logic [13:0] off, input logic [1:0] k);
    start_lookup(vpn, off, k);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_fill(input logic [25:0] vpn, input logic [21:0] ppn,
                          input logic [2:0] r, input logic d);
    fill_valid  = 1'b1;
    fill_vpn    = vpn;
    fill_ppn    = ppn;
    fill_rights = r;
    fill_dirty  = d;
  endtask

  task automatic fill(input logic [25:0] vpn, input logic [21:0] ppn,
                      input logic [2:0] r, input logic d);
    @(negedge clk);
    set_fill(vpn, ppn, r, d);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: no response flagged out of reset.
    check({rsp_valid, rsp_hit, rsp_miss, rsp_fault} == 4'b0, "R2", "reset outputs",
          {60'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R3 R4 R5 R6 R7 R8.
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].fill) begin
        fill(VEC[i].vpn, VEC[i].ppn, VEC[i].rights, VEC[i].fdirty);
      end else begin
        lookup(VEC[i].vpn, VEC[i].off, VEC[i].kind);
        check_rsp($sformatf("R%0d vec%0d", VEC[i].rq, i), VEC[i].exp, VEC[i].ppn,
                  VEC[i].off, VEC[i].fdirty);
      end
    end

    // R2: strobe lasts one cycle only.
    @(negedge clk);
    check(!rsp_valid, "R2", "strobe after one cycle", {63'd0, rsp_valid}, 64'd0);

    // R9: invalidate everything.
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    lookup(VPN_A2, 14'h0042, K_RD);
    check_rsp("R9 inv A2", E_MISS, 22'h0, 14'h0, 1'b0);
    lookup(VPN_B, 14'h0042, K_RD);
    check_rsp("R9 inv B", E_MISS, 22'h0, 14'h0, 1'b0);

    // R9 + R5: fill in the invalidate cycle survives; fill dirty is loaded.
    lookup(VPN_A0, 14'h0, K_RD);  // rebuild something to be cleared
    fill(VPN_B, 22'h00111, 3'b111, 1'b0);
    @(negedge clk);
    inv_all = 1'b1;
    set_fill(VPN_A1, 22'h15555, 3'b111, 1'b1);
    @(negedge clk);
    inv_all = 1'b0;
    fill_valid = 1'b0;
    lookup(VPN_A1, 14'h0777, K_RD);
    check_rsp("R9 R5 fill after inv", E_HIT, 22'h15555, 14'h0777, 1'b1);
    lookup(VPN_B, 14'h0777, K_RD);
    check_rsp("R9 other cleared", E_MISS, 22'h0, 14'h0, 1'b0);

    // R10: response in the fill cycle sees old contents.
    start_lookup(VPN_E, 14'h0abc, K_RD);
    @(negedge clk);
    req_valid = 1'b0;
    set_fill(VPN_E, 22'h02468, 3'b111, 1'b0);
    check_rsp("R10 old contents", E_MISS, 22'h0, 14'h0, 1'b0);
    @(negedge clk);
    fill_valid = 1'b0;
    lookup(VPN_E, 14'h0abc, K_RD);
    check_rsp("R10 fill landed", E_HIT, 22'h02468, 14'h0abc, 1'b0);

    // R10 + R8: in-place refill beats a write hit's dirty update.
    start_lookup(VPN_E, 14'h0001, K_WR);
    @(negedge clk);
    req_valid = 1'b0;
    set_fill(VPN_E, 22'h01357, 3'b111, 1'b0);
    check_rsp("R10 hit old frame", E_HIT, 22'h02468, 14'h0001, 1'b0);
    @(negedge clk);
    fill_valid = 1'b0;
    lookup(VPN_E, 14'h0002, K_RD);
    check_rsp("R10 fill wins dirty", E_HIT, 22'h01357, 14'h0002, 1'b0);

    finish_run();
  end

endmodule